// File: doc/BRIEF.md
# Per-Channel Idle Code Array

This block keeps an 8-bit idle code for each timeslot channel of a T1 or E1 link. There are two banks of codes, one for the transmit direction and one for the receive direction. A host reaches both banks indirectly, through two byte-wide registers. The control register holds a channel pointer and two broadcast flags. The data register is the write window: one write to it stores its byte into the selected entry, or into every entry of one or both banks.

Channels are numbered from 1. A `mode_e1` input sets the channel count, which is 32 when the input is high and 24 when it is low. For single-entry accesses, a `bank_sel` input picks the bank. A combinational lookup port returns the code of any channel in either bank. A serializer loads the transmit code of a chosen channel when it sees a start pulse, then shifts that code out most significant bit first, one bit per bit-enable.

Top module: `idle_code_array`

## Requirements
- R1: After reset the control register reads 00h, every stored code in both banks is 00h, `err_flag` is 0, `ser_busy` is 0 and `ser_out` is 0.
- R2: A register write takes effect on the clock edge that samples the strobe. `reg_addr`=0 is the control register and `reg_addr`=1 is the data register. In the control register, bits 5:0 are the channel pointer (bit 0 is the LSB), bit 6 is the transmit broadcast flag and bit 7 is the receive broadcast flag. A read of address 0 returns the whole control byte.
- R3: When both flags are 0, a data write stores the byte only in the entry named by the pointer. That entry is in the transmit bank when `bank_sel`=0 and in the receive bank when `bank_sel`=1. Pointer 01h is channel 1.
- R4: When only the transmit flag is set, a data write stores the byte in every transmit entry of the current mode and leaves the receive bank unchanged.
- R5: When only the receive flag is set, a data write stores the byte in every receive entry of the current mode and leaves the transmit bank unchanged.
- R6: When both flags are set, a data write stores the byte in every transmit entry and every receive entry of the current mode.
- R7: A broadcast covers channels 1–24 when `mode_e1`=0 and channels 1–32 when `mode_e1`=1. In T1 mode, entries 25–32 keep their old values.
- R8: A single-entry data write whose pointer is 00h, or is above the mode's channel count, changes no entry. It sets `err_flag`, which stays at 1 until reset.
- R9: A read of address 1 returns, on the cycle after `reg_rd`, the code stored for the pointed channel in the bank chosen by `bank_sel`. If either flag is set, the read returns 00h.
- R10: `look_code` gives, with no clock delay, the code of channel `look_ch` in the bank chosen by `look_bank` (0 is transmit). If `look_ch` is 0 or above 32, `look_code` is 00h.
- R11: A `ser_start` pulse loads the transmit code of `ser_ch` and sets `ser_busy`. Bit 7 appears on `ser_out` right away. Each `bit_en` then shifts the next lower bit onto `ser_out`. `ser_busy` drops after the eighth `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_e1 | input | 1 | 1 = 32 channels, 0 = 24 channels |
| bank_sel | input | 1 | Bank for single-entry accesses (0 transmit, 1 receive) |
| reg_addr | input | 1 | 0 = control register, 1 = data register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| err_flag | output | 1 | Sticky flag for a single write with a bad pointer |
| look_ch | input | 6 | Lookup channel number |
| look_bank | input | 1 | Lookup bank (0 transmit, 1 receive) |
| look_code | output | 8 | Stored code of the looked-up channel |
| ser_start | input | 1 | Load pulse for the serializer |
| ser_ch | input | 6 | Channel whose transmit code is loaded |
| bit_en | input | 1 | Shift enable, one bit per pulse |
| ser_out | output | 1 | Serial code output, MSB first |
| ser_busy | output | 1 | High while code bits remain to be sent |

## Verification
The assertions check four things on every cycle. A control write lands exactly as written. A transmit broadcast reaches channel 1. A bad single write raises the error flag, and the flag never clears by itself. The serializer turns busy after a start pulse, and its bit count never goes above eight. Some things only the directed scenarios can show. These are the exact set of entries a write touches, the entries a broadcast leaves alone, a 24-channel broadcast stopping at channel 24, read data returning zero while a flag is set, and the order of bits on the serial line.

// File: rtl/idle_code_array.sv
module idle_code_array #(
  parameter int NUM_CH = 32,
  parameter int T1_CH  = 24,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_e1,
  input  logic              bank_sel,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              err_flag,
  input  logic [5:0]        look_ch,
  input  logic              look_bank,
  output logic [CODE_W-1:0] look_code,
  input  logic              ser_start,
  input  logic [5:0]        ser_ch,
  input  logic              bit_en,
  output logic              ser_out,
  output logic              ser_busy
);
  localparam int CH_W  = 6;
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [7:0]        ctrl;
  logic [CODE_W-1:0] tx_mem [NUM_CH];
  logic [CODE_W-1:0] rx_mem [NUM_CH];
  logic [CODE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire [CH_W-1:0] ptr    = ctrl[5:0];
  wire            g_tx   = ctrl[6];
  wire            g_rx   = ctrl[7];
  wire [CH_W-1:0] nch    = mode_e1 ? CH_W'(NUM_CH) : CH_W'(T1_CH);
  wire            ptr_ok = (ptr != '0) && (ptr <= nch);
  wire            dwr    = reg_wr && reg_addr;
  wire            single = dwr && !g_tx && !g_rx;

  function automatic logic [CODE_W-1:0] pick(input logic [CH_W-1:0] ch, input logic bank,
                                             input logic [CODE_W-1:0] tm [NUM_CH],
                                             input logic [CODE_W-1:0] rm [NUM_CH]);
    logic [CODE_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch == CH_W'(i + 1)) v = bank ? rm[i] : tm[i];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      err_flag <= 1'b0;
    end else begin
      if (reg_wr && !reg_addr) ctrl <= reg_wdata;
      if (single && !ptr_ok) err_flag <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
    wire in_mode = CH_W'(i + 1) <= nch;
    wire hit     = single && ptr_ok && (ptr == CH_W'(i + 1));
    wire tx_we   = (dwr && g_tx && in_mode) || (hit && !bank_sel);
    wire rx_we   = (dwr && g_rx && in_mode) || (hit && bank_sel);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_mem[i] <= '0;
        rx_mem[i] <= '0;
      end else begin
        if (tx_we) tx_mem[i] <= reg_wdata[CODE_W-1:0];
        if (rx_we) rx_mem[i] <= reg_wdata[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      if (!reg_addr) reg_rdata <= ctrl;
      else if (g_tx || g_rx) reg_rdata <= '0;
      else reg_rdata <= 8'(pick(ptr, bank_sel, tx_mem, rx_mem));
    end
  end

  assign look_code = pick(look_ch, look_bank, tx_mem, rx_mem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (ser_start) begin
      shreg <= pick(ser_ch, 1'b0, tx_mem, rx_mem);
      cnt   <= CNT_W'(CODE_W);
    end else if (bit_en && cnt != '0) begin
      shreg <= shreg << 1;
      cnt   <= cnt - 1'b1;
    end
  end

  assign ser_out  = shreg[CODE_W-1];
  assign ser_busy = cnt != '0;

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> ctrl == $past(reg_wdata));
  // R4
  tx_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && g_tx) |=> tx_mem[0] == $past(reg_wdata[CODE_W-1:0]));
  // R8
  bad_ptr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !ptr_ok) |=> err_flag);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R11
  ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> ser_busy);
  // R11
  ser_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CODE_W));
endmodule

// File: tb/idle_code_array_tb.sv
module idle_code_array_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mode_e1 = 1, bank_sel = 0;
  logic reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic err_flag;
  logic [5:0] look_ch = 0;
  logic look_bank = 0;
  logic [7:0] look_code;
  logic ser_start = 0, bit_en = 0, ser_out, ser_busy;
  logic [5:0] ser_ch = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_code_array u_dut (
    .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .bank_sel(bank_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .err_flag(err_flag), .look_ch(look_ch), .look_bank(look_bank),
    .look_code(look_code), .ser_start(ser_start), .ser_ch(ser_ch), .bit_en(bit_en),
    .ser_out(ser_out), .ser_busy(ser_busy));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic look(logic b, logic [5:0] ch, output logic [7:0] d);
    look_bank = b; look_ch = ch; #1; d = look_code;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    look(0, 1, d);  chk("R1 tx ch1", d, 0);
    look(1, 32, d); chk("R1 rx ch32", d, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 busy", ser_busy, 0);
    chk("R1 ser_out", ser_out, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(0, 8'hC5); rd(0, d); chk("R2 ctrl readback", d, 8'hC5);
  endtask

  task automatic t_single();
    logic [7:0] d;
    mode_e1 = 1;
    bank_sel = 0; wr(0, 8'h03); wr(1, 8'hA5);
    look(0, 3, d); chk("R3 tx ch3", d, 8'hA5);
    look(0, 2, d); chk("R3 tx ch2 untouched", d, 0);
    look(1, 3, d); chk("R3 rx ch3 untouched", d, 0);
    bank_sel = 1; wr(0, 8'h20); wr(1, 8'h3C);
    look(1, 32, d); chk("R3 rx ch32", d, 8'h3C);
    look(0, 32, d); chk("R3 tx ch32 untouched", d, 0);
    bank_sel = 0; wr(0, 8'h01); wr(1, 8'h11);
    look(0, 1, d); chk("R3 tx ch1", d, 8'h11);
  endtask

  task automatic t_read();
    logic [7:0] d;
    bank_sel = 0; wr(0, 8'h03); rd(1, d); chk("R9 read tx ch3", d, 8'hA5);
    bank_sel = 1; wr(0, 8'h20); rd(1, d); chk("R9 read rx ch32", d, 8'h3C);
    wr(0, 8'h60); rd(1, d); chk("R9 read with flag", d, 0);
    bank_sel = 0;
  endtask

  task automatic t_bcast();
    logic [7:0] d;
    mode_e1 = 1;
    wr(0, 8'h40); wr(1, 8'h77);
    for (int c = 1; c <= 32; c++) begin look(0, 6'(c), d); chk("R4 tx all", d, 8'h77); end
    look(1, 32, d); chk("R4 rx untouched", d, 8'h3C);
    wr(0, 8'h80); wr(1, 8'h88);
    look(1, 1, d);  chk("R5 rx ch1", d, 8'h88);
    look(1, 32, d); chk("R5 rx ch32", d, 8'h88);
    look(0, 9, d);  chk("R5 tx untouched", d, 8'h77);
    mode_e1 = 0;
    wr(0, 8'hC0); wr(1, 8'h99);
    look(0, 24, d); chk("R6 tx ch24", d, 8'h99);
    look(1, 1, d);  chk("R6 rx ch1", d, 8'h99);
    look(0, 25, d); chk("R7 tx ch25 kept", d, 8'h77);
    look(1, 32, d); chk("R7 rx ch32 kept", d, 8'h88);
  endtask

  task automatic t_err();
    logic [7:0] d;
    mode_e1 = 0; bank_sel = 0;
    chk("R8 err clear before", err_flag, 0);
    wr(0, 8'h19); wr(1, 8'h5A);
    look(0, 25, d); chk("R8 ignored", d, 8'h77);
    chk("R8 err set", err_flag, 1);
    wr(0, 8'h00); wr(1, 8'h5A);
    look(0, 1, d); chk("R8 ptr0 ignored", d, 8'h99);
    wr(0, 8'h02); wr(1, 8'h42);
    chk("R8 err sticky", err_flag, 1);
    look(0, 0, d);  chk("R10 ch0 zero", d, 0);
    look(0, 40, d); chk("R10 ch40 zero", d, 0);
    look(0, 2, d);  chk("R10 tx ch2", d, 8'h42);
  endtask

  task automatic t_ser();
    logic [7:0] code = 8'hB2;
    mode_e1 = 1; bank_sel = 0;
    wr(0, 8'h05); wr(1, code);
    @(negedge clk); ser_ch = 5; ser_start = 1;
    @(negedge clk); ser_start = 0;
    chk("R11 busy", ser_busy, 1);
    for (int k = 7; k >= 0; k--) begin
      chk("R11 bit", ser_out, code[k]);
      bit_en = 1; @(negedge clk); bit_en = 0;
      if (k > 0) chk("R11 still busy", ser_busy, 1);
    end
    chk("R11 done", ser_busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctrl(); t_single(); t_read(); t_bcast(); t_err(); t_ser();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule